// File: doc/BRIEF.md
# SPI Host Controller

This block is a single-master synchronous serial controller that sits on a small register bus. Software sets the serial clock rate, the clock polarity, the clock phase and the word length, then writes a word to the data register. That write loads the shift register directly and starts the transfer at once. The block drives the serial clock, the outgoing data line and an active-low select, and samples the incoming data line. When the last bit has been exchanged, it moves the received word into a single read buffer.

There is no transmit holding stage, so software has to pace its writes. Status flags report completion and three misuse conditions: a write while the shifter is still owned by a transfer, a completed word arriving while the previous one is still unread, and another device driving the external select input. Software acknowledges flags by reading the status register and then accessing the data register.

Register offsets on the bus: 0 control, 1 divider, 2 data, 3 status. Reads return data on the clock after the read strobe.

Top module: `spi_host_ctrl`

## Requirements
- R1: While the select output is high, the serial clock rests at the polarity bit (control bit 0): low for 0, high for 1. A change of that bit reaches the pin one clock later.
- R2: Phase bit (control bit 1) = 0 samples the incoming line on the first clock edge of each bit and changes the outgoing line on the second. Phase = 1 changes the outgoing line on the first edge and samples on the second. The outgoing line changes only together with a serial clock edge while the select is low.
- R3: The outgoing word leaves most-significant bit first. Incoming bits enter at the least-significant end, so the received word holds the first-arrived bit in its top position.
- R4: Control bits [5:2] hold a length code n. A transfer moves 8+n bits, and codes above 8 give 16 bits.
- R5: The divider register (offset 1) holds the serial clock half-period in system clocks. A written value below 4 is stored as 4, so a bit never takes less than 8 system clocks. Each half-period lasts exactly the stored count.
- R6: The select output falls on the clock edge that accepts the data write. The first serial clock edge comes exactly one half-period later, and the select rises exactly one half-period after the last edge.
- R7: A data write (offset 2) with the shifter idle and no unacknowledged completion starts a transfer. At its end the received word goes to the read buffer and status bit 0 (complete) sets. Status bit 4 reads 1 while a transfer is running.
- R8: If a transfer completes while the read buffer still holds an unread word, status bit 2 (overrun) sets and the buffer keeps the older word.
- R9: A data write while a transfer runs, or while the complete flag is set but not yet observed by a status read, is discarded. It sets status bit 1 (collision), does not alter the word in flight and starts nothing.
- R10: A low level on the external select input, after two synchronising clocks, sets status bit 3 (mode fault), aborts any running transfer, and releases the select. Data writes start nothing while that flag is set.
- R11: A status read (offset 3) records which flags were set at that moment. The next data-register read or write clears exactly those flags. A flag raised after the status read survives.
- R12: After reset the select is high, the serial clock and outgoing line are low, the status reads 0, and the divider reads 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the clock after the read strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Outgoing serial data |
| spi_cs_n | output | 1 | Active-low select to the peripheral |
| spi_miso | input | 1 | Incoming serial data |
| ss_in_n | input | 1 | External active-low select sense, used for mode-fault detection |

## Verification
The hardest state to reach from the pins is read overrun. The complete flag blocks new data writes until software has observed it, so a second word can only arrive on top of an unread one through a narrow path. The stimulus reads status, changes the mode, and then writes the data register without reading the buffer. That write acknowledges the completion and starts the next transfer, and the bench checks that the older word is still there afterwards. The partial-clear rule is reached in a similar way: the stimulus pulses the external select between a status read and the following data access.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  typedef enum logic [1:0] {ENG_IDLE, ENG_LEAD, ENG_RUN, ENG_TAIL} eng_state_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DIV  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int FLAG_N   = 4;
  localparam int ST_DONE  = 0;
  localparam int ST_WCOL  = 1;
  localparam int ST_ROVR  = 2;
  localparam int ST_MODF  = 3;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cnt,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == half_cnt - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_host_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = 5,
  parameter int DIV_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [MAX_BITS-1:0] tx_word,
  input  logic [LEN_W-1:0]    len_cfg,
  input  logic                cpol_cfg,
  input  logic                cpha_cfg,
  input  logic [DIV_W-1:0]    half_cfg,
  input  logic                abort,
  input  logic                miso,
  output logic                sclk,
  output logic                mosi,
  output logic                cs_n,
  output logic                busy,
  output logic                done,
  output logic [MAX_BITS-1:0] rx_word
);
  eng_state_t          st;
  logic [MAX_BITS-1:0] sh, aligned, rx_mask;
  logic [LEN_W-1:0]    len_l, bitn;
  logic [DIV_W-1:0]    half_l;
  logic                cpol_l, cpha_l, second, smp, tick;

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .run(busy), .half_cnt(half_l), .tick(tick)
  );

  assign busy    = (st != ENG_IDLE);
  assign aligned = tx_word << (LEN_W'(MAX_BITS) - len_cfg);

  always_comb begin
    for (int i = 0; i < MAX_BITS; i++) rx_mask[i] = (i < int'(len_l));
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      st <= ENG_IDLE; sh <= '0; len_l <= '0; bitn <= '0; half_l <= '0;
      cpol_l <= 1'b0; cpha_l <= 1'b0; second <= 1'b0; smp <= 1'b0;
      sclk <= 1'b0; mosi <= 1'b0; cs_n <= 1'b1; rx_word <= '0;
    end else if (st == ENG_IDLE) begin
      sclk <= cpol_cfg;
      if (start) begin
        sh     <= aligned;
        mosi   <= aligned[MAX_BITS-1];
        len_l  <= len_cfg;
        half_l <= half_cfg;
        cpol_l <= cpol_cfg;
        cpha_l <= cpha_cfg;
        bitn   <= '0;
        second <= 1'b0;
        cs_n   <= 1'b0;
        st     <= ENG_LEAD;
      end
    end else if (abort) begin
      st   <= ENG_IDLE;
      cs_n <= 1'b1;
      sclk <= cpol_l;
    end else if (tick) begin
      if (st == ENG_TAIL) begin
        st      <= ENG_IDLE;
        cs_n    <= 1'b1;
        done    <= 1'b1;
        rx_word <= sh & rx_mask;
      end else if (st == ENG_LEAD || !second) begin
        // first edge of a bit
        sclk   <= ~cpol_l;
        second <= 1'b1;
        st     <= ENG_RUN;
        if (cpha_l) mosi <= sh[MAX_BITS-1];
        else        smp  <= miso;
      end else begin
        // second edge of a bit
        sclk   <= cpol_l;
        second <= 1'b0;
        sh     <= {sh[MAX_BITS-2:0], cpha_l ? miso : smp};
        if (!cpha_l) mosi <= sh[MAX_BITS-2];
        if (bitn == len_l - LEN_W'(1)) st <= ENG_TAIL;
        else                           bitn <= bitn + LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit
  import spi_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_rd,
  input  logic              data_acc,
  input  logic [FLAG_N-1:0] set_evt,
  output logic [FLAG_N-1:0] flags,
  output logic              seen_done
);
  logic [FLAG_N-1:0] seen;

  assign seen_done = seen[ST_DONE];

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      seen  <= '0;
    end else begin
      if (stat_rd) seen <= flags;
      if (data_acc) begin
        flags <= (flags & ~seen) | set_evt;
        seen  <= '0;
      end else begin
        flags <= flags | set_evt;
      end
    end
  end
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int MAX_BITS = 16,
  parameter int MIN_BITS = 8,
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [1:0]          reg_addr,
  input  logic [MAX_BITS-1:0] reg_wdata,
  output logic [MAX_BITS-1:0] reg_rdata,
  output logic                spi_sclk,
  output logic                spi_mosi,
  output logic                spi_cs_n,
  input  logic                spi_miso,
  input  logic                ss_in_n
);
  localparam int LEN_W  = $clog2(MAX_BITS + 1);
  localparam int SPAN   = MAX_BITS - MIN_BITS;
  localparam int LENF_W = $clog2(SPAN + 1);
  localparam int CTRL_W = 2 + LENF_W;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [DIV_W-1:0]    div_q;
  logic [MAX_BITS-1:0] rx_buf, eng_rx;
  logic [LEN_W-1:0]    xfer_len;
  logic [FLAG_N-1:0]   flags, set_evt;
  logic                cfg_cpol, cfg_cpha, ss_meta, ss_sync, rx_unread, unread_eff;
  logic                hit_data_wr, hit_data_rd, hit_stat_rd, eng_busy, eng_done;
  logic                seen_done, collide, start;

  assign cfg_cpol    = ctrl_q[0];
  assign cfg_cpha    = ctrl_q[1];
  assign hit_data_wr = reg_wr && reg_addr == ADDR_DATA;
  assign hit_data_rd = reg_rd && reg_addr == ADDR_DATA;
  assign hit_stat_rd = reg_rd && reg_addr == ADDR_STAT;

  always_comb begin
    if (int'(ctrl_q[CTRL_W-1:2]) > SPAN) xfer_len = LEN_W'(MAX_BITS);
    else xfer_len = LEN_W'(MIN_BITS + int'(ctrl_q[CTRL_W-1:2]));
  end

  assign collide = hit_data_wr && (eng_busy || (flags[ST_DONE] && !seen_done));
  assign start   = hit_data_wr && !collide && !flags[ST_MODF] && ss_sync;

  assign unread_eff       = rx_unread && !hit_data_rd;
  assign set_evt[ST_DONE] = eng_done;
  assign set_evt[ST_WCOL] = collide;
  assign set_evt[ST_ROVR] = eng_done && unread_eff;
  assign set_evt[ST_MODF] = !ss_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_meta <= 1'b1;
      ss_sync <= 1'b1;
    end else begin
      ss_meta <= ss_in_n;
      ss_sync <= ss_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      div_q  <= DIV_W'(MIN_HALF);
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (reg_addr == ADDR_DIV) begin
        if (reg_wdata[DIV_W-1:0] < DIV_W'(MIN_HALF)) div_q <= DIV_W'(MIN_HALF);
        else                                         div_q <= reg_wdata[DIV_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf    <= '0;
      rx_unread <= 1'b0;
    end else if (eng_done && !unread_eff) begin
      rx_buf    <= eng_rx;
      rx_unread <= 1'b1;
    end else if (hit_data_rd) begin
      rx_unread <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        ADDR_CTRL: reg_rdata <= MAX_BITS'(ctrl_q);
        ADDR_DIV:  reg_rdata <= MAX_BITS'(div_q);
        ADDR_DATA: reg_rdata <= rx_buf;
        default:   reg_rdata <= MAX_BITS'({eng_busy, flags});
      endcase
    end
  end

  spi_flag_unit u_flags (
    .clk(clk), .rst(rst), .stat_rd(hit_stat_rd),
    .data_acc(hit_data_wr || hit_data_rd), .set_evt(set_evt),
    .flags(flags), .seen_done(seen_done)
  );

  spi_shift_engine #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_engine (
    .clk(clk), .rst(rst), .start(start), .tx_word(reg_wdata), .len_cfg(xfer_len),
    .cpol_cfg(cfg_cpol), .cpha_cfg(cfg_cpha), .half_cfg(div_q), .abort(!ss_sync),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .busy(eng_busy), .done(eng_done), .rx_word(eng_rx)
  );
endmodule

// File: rtl/spi_host_ctrl_chk.sv
module spi_host_ctrl_chk #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             spi_sclk,
  input logic             spi_mosi,
  input logic             spi_cs_n,
  input logic             cfg_cpol,
  input logic [DIV_W-1:0] div_q,
  input logic             hit_data_wr,
  input logic             hit_data_rd,
  input logic             eng_busy,
  input logic             eng_done,
  input logic             rx_unread,
  input logic             ss_sync,
  input logic [3:0]       flags
);
  a_r1_idle_level: assert property (@(posedge clk) disable iff (rst)
    (spi_cs_n && $past(spi_cs_n)) |-> (spi_sclk == $past(cfg_cpol)));

  a_r2_mosi_on_edge: assert property (@(posedge clk) disable iff (rst)
    (!spi_cs_n && $past(!spi_cs_n) && !$stable(spi_mosi)) |-> !$stable(spi_sclk));

  a_r5_div_floor: assert property (@(posedge clk) disable iff (rst)
    div_q >= DIV_W'(MIN_HALF));

  a_r8_overrun_flag: assert property (@(posedge clk) disable iff (rst)
    (eng_done && rx_unread && !hit_data_rd) |=> flags[2]);

  a_r9_collision_flag: assert property (@(posedge clk) disable iff (rst)
    (hit_data_wr && eng_busy) |=> flags[1]);

  a_r10_fault_release: assert property (@(posedge clk) disable iff (rst)
    !ss_sync |=> (spi_cs_n && flags[3]));
endmodule

bind spi_host_ctrl spi_host_ctrl_chk #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_chk (
  .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
  .cfg_cpol(cfg_cpol), .div_q(div_q), .hit_data_wr(hit_data_wr), .hit_data_rd(hit_data_rd),
  .eng_busy(eng_busy), .eng_done(eng_done), .rx_unread(rx_unread), .ss_sync(ss_sync),
  .flags(flags)
);

// File: tb/spi_host_ctrl_bench.sv
module spi_host_ctrl_bench;
  logic        clk = 1'b0, rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0, reg_rdata;
  logic        spi_sclk, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0, ss_in_n = 1'b1;

  int total = 0, bad = 0, cyc = 0;

  // reference state of the bench
  logic        cpol_m = 1'b0, cpol_d = 1'b0, cpol_x = 1'b0, cpha_x = 1'b0;
  int          half_m = 4, len_x = 8, gap = 0, k = 0;
  logic [15:0] stx = 16'd0, mcap = 16'd0;
  logic        prev_cs = 1'b1, prev_sclk = 1'b0, abort_m = 1'b0, first_edge = 1'b0;

  spi_host_ctrl u_spi_host_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .ss_in_n(ss_in_n)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the pins against the reference; also acts as slave
  always @(negedge clk) begin
    if (!rst) begin
      if (spi_cs_n && prev_cs)
        check(spi_sclk === cpol_d, "R1 idle sclk level", int'(spi_sclk), int'(cpol_d));
      cpol_d = cpol_m;
      gap++;
      if (prev_cs && !spi_cs_n) begin
        gap = 0; k = 0; mcap = 16'd0; first_edge = 1'b1;
        spi_miso = stx[len_x-1];
      end else if (!prev_cs && spi_cs_n) begin
        if (!abort_m) check(gap == half_m, "R6 select release delay", gap, half_m);
      end else if (!spi_cs_n && spi_sclk !== prev_sclk) begin
        if (first_edge) check(gap == half_m, "R6 select setup delay", gap, half_m);
        else            check(gap == half_m, "R5 half-period length", gap, half_m);
        first_edge = 1'b0;
        gap = 0;
        if (spi_sclk !== cpol_x) begin
          if (!cpha_x) mcap = {mcap[14:0], spi_mosi};
          else if (k < len_x) spi_miso = stx[len_x-1-k];
        end else begin
          if (cpha_x) mcap = {mcap[14:0], spi_mosi};
          k++;
          if (!cpha_x && k < len_x) spi_miso = stx[len_x-1-k];
        end
      end
      prev_cs = spi_cs_n;
      prev_sclk = spi_sclk;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    if (a == 2'd0) cpol_m = d[0];
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic set_mode(input logic [15:0] c, input int len, input logic [15:0] slave);
    wr(2'd0, c);
    cpol_x = c[0]; cpha_x = c[1]; len_x = len; stx = slave;
  endtask

  task automatic wait_end();
    while (spi_cs_n) @(negedge clk);
    while (!spi_cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_rd(input logic [1:0] a, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    rd(a, v);
    check(v === exp, tag, int'(v), int'(exp));
  endtask

  task automatic quiet_select(input string tag);
    int lows = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!spi_cs_n) lows++;
    end
    check(lows == 0, tag, lows, 0);
  endtask

  task automatic pulse_ss();
    @(negedge clk); ss_in_n = 1'b0;
    repeat (3) @(negedge clk);
    ss_in_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check(spi_cs_n === 1'b1, "R12 select after reset", int'(spi_cs_n), 1);
    check(spi_sclk === 1'b0, "R12 sclk after reset", int'(spi_sclk), 0);
    check(spi_mosi === 1'b0, "R12 mosi after reset", int'(spi_mosi), 0);
    expect_rd(2'd3, 16'h0000, "R12 status after reset");
    expect_rd(2'd1, 16'h0004, "R12 divider after reset");
    // R5 floor on the divider
    wr(2'd1, 16'h0001);
    expect_rd(2'd1, 16'h0004, "R5 divider clamp");
    wr(2'd1, 16'h0006); half_m = 6;
    expect_rd(2'd1, 16'h0006, "R5 divider readback");

    // A: polarity 0, phase 0, 8 bits
    set_mode(16'h0000, 8, 16'h003C);
    wr(2'd2, 16'h00A5);
    wait_end();
    check(mcap === 16'h00A5, "R3 R2 mode0 outgoing bits", int'(mcap), 'hA5);
    expect_rd(2'd3, 16'h0001, "R7 complete flag");
    expect_rd(2'd2, 16'h003C, "R7 R3 received word mode0");
    expect_rd(2'd3, 16'h0000, "R11 flags cleared");

    // B: polarity 1, phase 1, 12 bits, collision while busy
    set_mode(16'h0013, 12, 16'h05E1);
    repeat (2) @(negedge clk);
    check(spi_sclk === 1'b1, "R1 idle high after polarity write", int'(spi_sclk), 1);
    wr(2'd2, 16'h0ABC);
    repeat (10) @(negedge clk);
    expect_rd(2'd3, 16'h0010, "R7 busy bit");
    wr(2'd2, 16'h00FF);
    wait_end();
    check(mcap === 16'h0ABC, "R9 R4 word in flight unchanged", int'(mcap), 'hABC);
    expect_rd(2'd3, 16'h0003, "R9 collision flag");
    expect_rd(2'd2, 16'h05E1, "R2 R4 received word mode3");
    expect_rd(2'd3, 16'h0000, "R11 flags cleared after collision");

    // C: polarity 1, phase 0, length code 15 -> 16 bits
    set_mode(16'h003D, 16, 16'hC3A5);
    wr(2'd2, 16'h8E71);
    wait_end();
    check(mcap === 16'h8E71, "R4 R2 sixteen-bit outgoing", int'(mcap), 'h8E71);
    expect_rd(2'd3, 16'h0001, "R7 complete after 16 bits");
    // D: start without reading the buffer -> overrun
    set_mode(16'h0002, 8, 16'h0096);
    wr(2'd2, 16'h003C);
    wait_end();
    check(mcap === 16'h003C, "R2 mode1 outgoing bits", int'(mcap), 'h3C);
    expect_rd(2'd3, 16'h0005, "R8 overrun flag");
    expect_rd(2'd2, 16'hC3A5, "R8 buffer keeps older word");
    expect_rd(2'd3, 16'h0000, "R11 overrun cleared");

    // E: minimum divider, then a write with an unobserved completion
    wr(2'd1, 16'h0002); half_m = 4;
    set_mode(16'h0000, 8, 16'h0081);
    wr(2'd2, 16'h0042);
    wait_end();
    check(mcap === 16'h0042, "R5 transfer at floor rate", int'(mcap), 'h42);
    wr(2'd2, 16'h0011);
    quiet_select("R9 discarded write starts nothing");
    expect_rd(2'd3, 16'h0003, "R9 collision on unobserved completion");
    // partial clear: fault raised after the status read survives
    pulse_ss();
    expect_rd(2'd2, 16'h0081, "R7 received word at floor rate");
    expect_rd(2'd3, 16'h0008, "R11 later flag survives");
    wr(2'd2, 16'h0055);
    quiet_select("R10 write ignored under mode fault");
    expect_rd(2'd3, 16'h0000, "R11 fault cleared by data access");

    // G: fault in the middle of a transfer
    set_mode(16'h0000, 8, 16'h00F0);
    wr(2'd2, 16'h0077);
    repeat (10) @(negedge clk);
    abort_m = 1'b1;
    @(negedge clk); ss_in_n = 1'b0;
    repeat (4) @(negedge clk);
    check(spi_cs_n === 1'b1, "R10 select released on fault", int'(spi_cs_n), 1);
    ss_in_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_rd(2'd3, 16'h0008, "R10 fault flag without completion");
    expect_rd(2'd2, 16'h0081, "R10 buffer untouched by abort");
    expect_rd(2'd3, 16'h0000, "R11 fault cleared");
    abort_m = 1'b0;

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule